// File: doc/BRIEF.md
# Synchronous DRAM Burst Data Path Model

This block is a cycle-accurate device-side model of the data side of a single-bank synchronous DRAM with a small on-chip array. On each rising clock edge it takes one command: no-operation, read, write or mode load. A mode load copies the address bus into a mode register that sets the burst length, the read latency and whether writes burst. Reads come back on `dq_out` after the programmed latency. The driver enable `dq_oe` goes high one cycle before the first word and drops in the cycle after the last one.

Writes take the word on `dq_in` at the same edge as the command. Each following idle cycle then stores the next burst word. A new read or write cuts off any burst in progress, so back-to-back reads give an unbroken stream of words. The DQ bus is modelled as separate in and out buses plus an enable. A DRAM data bus has no back-pressure, so the block has no valid/ready handshake: `dq_valid` marks the read words, and the host must take each one in the cycle it appears.

Top module: `sdr_burst_dp`

## Requirements
- R1: After reset, `dq_oe`, `dq_valid` and `mode_err` are 0 and `dq_out` is 0. The mode is latency 2, burst length 1, writes bursting.
- R2: A mode load (`cmd`=11) decodes `addr[2:0]` as burst length: 000, 001, 010 and 011 give 1, 2, 4 and 8 words, and any other code gives 1. It decodes `addr[6:4]` as latency: 010 gives 2 and 011 gives 3. `addr[9]`=1 makes writes single-location.
- R3: A mode load with `addr[8:7]` not 00, `addr[3]` not 0, or a latency code other than 010/011 sets `mode_err` and keeps the previous settings. A legal load clears `mode_err`.
- R4: A read (`cmd`=01) registered at edge n with latency m shows its first word on `dq_out` with `dq_valid`=1 after edge n+m. One word follows per cycle, and `dq_out` is 0 while `dq_valid` is 0.
- R5: `dq_oe` rises at edge n+m-1 and falls at the edge after the last burst word, edge n+m+L.
- R6: Burst word k of a burst of length L that starts at address a comes from address (a with its low log2(L) bits cleared) + ((a+k) mod L).
- R7: A write (`cmd`=10) stores `dq_in` at `addr` on the command edge. Each following no-operation edge stores `dq_in` at the next burst address (same order as R6) until L words have been written.
- R8: With the single-location write mode set, a write stores only the addressed word, and data driven in the following cycles is ignored. Reads still burst with the programmed length.
- R9: A read, write or mode load cuts off a burst in progress. A read issued while a read burst is running continues the output stream with no idle cycle between the two bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands registered on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 2 | 00 no-op, 01 read, 10 write, 11 mode load |
| addr | input | ADDR_W | Word address for read/write; mode value for mode load |
| dq_in | input | DATA_W | Write data, sampled on command and burst edges |
| dq_out | output | DATA_W | Read data, zero when not valid |
| dq_oe | output | 1 | Data driver enable, leads the first read word by one cycle |
| dq_valid | output | 1 | Marks a read word on `dq_out` |
| mode_err | output | 1 | Last mode load held a reserved value |

## Verification
The assertions assume the host never changes the read latency while read words are still in the pipeline. A mid-flight change would move the output tap and break the enable-leads-data relation. The stimulus therefore always lets every read burst drain, including the cycle where the enable falls, before it issues the next mode load. The checks also assume that every location a read touches has been written. The bench first fills the whole array with known data, and every later read expectation comes from that image plus the writes the bench tracks.

// File: rtl/sdr_pkg.sv
`timescale 1ns/1ps
package sdr_pkg;
  typedef enum logic [1:0] {
    CMD_NOP     = 2'b00,
    CMD_READ    = 2'b01,
    CMD_WRITE   = 2'b10,
    CMD_SETMODE = 2'b11
  } cmd_e;

  typedef struct packed {
    logic [1:0] bl_log;    // burst length = 1 << bl_log
    logic       lat3;      // 1: latency 3, 0: latency 2
    logic       wr_single; // writes touch one location
  } mode_t;

  localparam mode_t MODE_RESET = '{bl_log: 2'd0, lat3: 1'b0, wr_single: 1'b0};
endpackage

// File: rtl/sdr_mode_reg.sv
`timescale 1ns/1ps
module sdr_mode_reg
  import sdr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] value,
  output mode_t             mode,
  output logic              err
);
  localparam int MODE_BITS = 10;

  logic [MODE_BITS-1:0] mv;
  logic                 op_ok;
  logic                 lat_ok;
  logic                 seq_ok;
  logic                 legal;
  mode_t                dec;

  assign mv     = value[MODE_BITS-1:0];
  assign op_ok  = (mv[8:7] == 2'b00);
  assign seq_ok = ~mv[3];
  assign lat_ok = (mv[6:4] == 3'b010) || (mv[6:4] == 3'b011);
  assign legal  = op_ok && seq_ok && lat_ok;

  always_comb begin
    dec.bl_log    = mv[2] ? 2'd0 : mv[1:0];
    dec.lat3      = mv[4];
    dec.wr_single = mv[9];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= MODE_RESET;
      err  <= 1'b0;
    end else if (load) begin
      if (legal) begin
        mode <= dec;
        err  <= 1'b0;
      end else begin
        err  <= 1'b1;
      end
    end
  end

  // R3: a reserved load flags and leaves the settings untouched
  p_bad_load_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !legal) |=> (err && $stable(mode)));

  // R3: a legal load clears the flag
  p_good_load_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && legal) |=> !err);
endmodule

// File: rtl/sdr_burst_seq.sv
`timescale 1ns/1ps
module sdr_burst_seq
  import sdr_pkg::*;
#(
  parameter int MEM_AW = 6   // at least 3 so an 8-word block fits
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [MEM_AW-1:0] cmd_addr,
  input  mode_t             mode,
  output logic              rd_iss,
  output logic [MEM_AW-1:0] rd_addr,
  output logic              wr_en,
  output logic [MEM_AW-1:0] wr_addr
);
  localparam int CNT_W = 3;

  logic              active;
  logic              is_wr;
  logic [MEM_AW-1:0] base;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        len_log;
  logic [CNT_W-1:0]  last_idx;
  logic [MEM_AW-1:0] msk;
  logic [MEM_AW-1:0] cur;
  logic [1:0]        wr_len_log;

  assign last_idx   = CNT_W'((4'd1 << len_log) - 4'd1);
  assign msk        = MEM_AW'(last_idx);
  assign cur        = (base & ~msk) | ((base + MEM_AW'(cnt)) & msk);
  assign wr_len_log = mode.wr_single ? 2'd0 : mode.bl_log;

  assign rd_iss  = active && !is_wr;
  assign rd_addr = cur;
  assign wr_en   = (cmd == CMD_WRITE) || (active && is_wr && cmd == CMD_NOP);
  assign wr_addr = (cmd == CMD_WRITE) ? cmd_addr : cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      is_wr   <= 1'b0;
      base    <= '0;
      cnt     <= '0;
      len_log <= '0;
    end else begin
      unique case (cmd)
        CMD_READ: begin
          active  <= 1'b1;
          is_wr   <= 1'b0;
          base    <= cmd_addr;
          cnt     <= '0;
          len_log <= mode.bl_log;
        end
        CMD_WRITE: begin
          active  <= (wr_len_log != 2'd0);
          is_wr   <= 1'b1;
          base    <= cmd_addr;
          cnt     <= CNT_W'(1);
          len_log <= wr_len_log;
        end
        CMD_SETMODE: active <= 1'b0;
        default: begin
          if (active) begin
            if (cnt == last_idx) active <= 1'b0;
            else                 cnt    <= cnt + CNT_W'(1);
          end
        end
      endcase
    end
  end

  // R6: the burst index never leaves the block
  p_cnt_in_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= last_idx));

  // R8: single-location writes leave no burst running
  p_single_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WRITE && mode.wr_single) |=> !active);
endmodule

// File: rtl/sdr_array.sv
`timescale 1ns/1ps
module sdr_array #(
  parameter int DATA_W = 16,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MEM_AW-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [MEM_AW-1:0] ra,
  output logic [DATA_W-1:0] rq
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rq <= mem[ra];
  end
endmodule

// File: rtl/sdr_rd_pipe.sv
`timescale 1ns/1ps
module sdr_rd_pipe #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss,
  input  logic [DATA_W-1:0] rq,
  input  logic              lat3,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              dq_valid
);
  logic              v1, v2, v3;
  logic [DATA_W-1:0] d2, d3;
  logic              v_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
      d2 <= '0;
      d3 <= '0;
    end else begin
      v1 <= iss;
      v2 <= v1;
      v3 <= v2;
      d2 <= rq;
      d3 <= d2;
    end
  end

  assign dq_valid = lat3 ? v3 : v2;
  assign v_next   = lat3 ? v2 : v1;
  assign dq_oe    = dq_valid || v_next;
  assign dq_out   = dq_valid ? (lat3 ? d3 : d2) : '0;

  // R5: the driver is already on in the cycle before a burst's first word
  p_oe_leads_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_valid) |-> $past(dq_oe));
endmodule

// File: rtl/sdr_burst_dp.sv
`timescale 1ns/1ps
module sdr_burst_dp
  import sdr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,  // at least 10: mode value width
  parameter int MEM_AW = 6    // array of 2**MEM_AW words, MEM_AW <= ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              dq_valid,
  output logic              mode_err
);
  cmd_e              c;
  mode_t             mode;
  logic              rd_iss;
  logic              wr_en;
  logic [MEM_AW-1:0] rd_addr;
  logic [MEM_AW-1:0] wr_addr;
  logic [DATA_W-1:0] rq;

  assign c = cmd_e'(cmd);

  sdr_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (c == CMD_SETMODE),
    .value (addr),
    .mode  (mode),
    .err   (mode_err)
  );

  sdr_burst_seq #(.MEM_AW(MEM_AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (c),
    .cmd_addr (addr[MEM_AW-1:0]),
    .mode     (mode),
    .rd_iss   (rd_iss),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr)
  );

  sdr_array #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_array (
    .clk (clk),
    .we  (wr_en),
    .wa  (wr_addr),
    .wd  (dq_in),
    .ra  (rd_addr),
    .rq  (rq)
  );

  sdr_rd_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .iss      (rd_iss),
    .rq       (rq),
    .lat3     (mode.lat3),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .dq_valid (dq_valid)
  );
endmodule

// File: tb/test_sdr_burst_dp.sv
`timescale 1ns/1ps
module test_sdr_burst_dp;
  localparam int DW = 16;
  localparam int AW = 10;
  localparam int NV = 6;
  // fields: [21:16] read start, [15:10] write start, [9:0] mode value
  localparam logic [21:0] VEC [NV] = '{
    {6'd6,  6'd6,  10'h022},  // BL4 lat2
    {6'd8,  6'd13, 10'h033},  // BL8 lat3, write wraps
    {6'd20, 6'd21, 10'h031},  // BL2 lat3
    {6'd30, 6'd30, 10'h020},  // BL1 lat2
    {6'd40, 6'd41, 10'h232},  // BL4 lat3, single writes
    {6'd50, 6'd50, 10'h027}   // reserved BL code -> 1
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cmd = 2'b00;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe, dq_valid, mode_err;

  int n_chk = 0;
  int n_err = 0;
  int cur_l = 1;
  int cur_m = 2;
  bit cur_ws = 1'b0;
  logic [DW-1:0] em [64];

  always #4 clk = ~clk;

  sdr_burst_dp i_sdr_burst_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_valid(dq_valid), .mode_err(mode_err)
  );

  function automatic int wrap(input int a, input int k, input int l);
    return (a & ~(l - 1) & 63) | ((a + k) & (l - 1));
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_mode(input logic [9:0] m);
    @(negedge clk);
    cmd = 2'b11; addr = AW'(m);
    @(negedge clk);
    cmd = 2'b00;
    if (m[8:7] == 2'b00 && !m[3] && (m[6:4] == 3'b010 || m[6:4] == 3'b011)) begin
      cur_l  = (m[2:0] <= 3'd3) ? (1 << m[1:0]) : 1;
      cur_m  = m[4] ? 3 : 2;
      cur_ws = m[9];
    end
  endtask

  task automatic write_burst(input int a, input int n_drive, input logic [DW-1:0] seed);
    int lm;
    lm = cur_ws ? 1 : cur_l;
    @(negedge clk);
    cmd = 2'b10; addr = AW'(a); dq_in = seed;
    for (int k = 1; k < n_drive; k++) begin
      @(negedge clk);
      cmd = 2'b00; dq_in = seed + DW'(k);
    end
    @(negedge clk);
    cmd = 2'b00; dq_in = '0;
    for (int k = 0; k < lm; k++) em[wrap(a, k, cur_l)] = seed + DW'(k);
  endtask

  task automatic read_check(input int a, input string dreq, input string vreq);
    @(negedge clk);
    cmd = 2'b01; addr = AW'(a);
    for (int j = 0; j <= cur_m + cur_l; j++) begin
      bit eo, ev;
      logic [DW-1:0] ed;
      @(negedge clk);
      if (j == 0) cmd = 2'b00;
      eo = (j >= cur_m - 1) && (j <= cur_m + cur_l - 1);
      ev = (j >= cur_m) && (j < cur_m + cur_l);
      ed = ev ? em[wrap(a, j - cur_m, cur_l)] : '0;
      chk(32'(dq_oe), 32'(eo), "R5", "driver enable");
      chk(32'(dq_valid), 32'(ev), vreq, "data valid");
      chk(32'(dq_out), 32'(ed), dreq, "read word");
    end
  endtask

  initial begin
    #(8 * 100000);
    n_err++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(32'(dq_oe), 0, "R1", "oe in reset");
    chk(32'(dq_valid), 0, "R1", "valid in reset");
    chk(32'(mode_err), 0, "R1", "err in reset");
    chk(32'(dq_out), 0, "R1", "data in reset");
    rst_n = 1'b1;
    // R1: default latency 2, length 1
    write_burst(0, 1, 16'h0AAA);
    read_check(0, "R1", "R1");

    // fill the whole array with known words (R7)
    set_mode(10'h023);
    chk(32'(mode_err), 0, "R2", "legal load");
    for (int b = 0; b < 8; b++) write_burst(b * 8, 8, 16'h1000 + DW'(b * 8));
    read_check(56, "R7", "R4");

    // table of mode / burst vectors
    for (int i = 0; i < NV; i++) begin
      set_mode(VEC[i][9:0]);
      write_burst(int'(VEC[i][15:10]), cur_l, 16'hC000 + DW'(i * 256));
      read_check(int'(VEC[i][21:16]), (i == 4) ? "R8" : "R6", "R2");
    end

    // R3: reserved operating mode, ordering bit and latency code
    set_mode(10'h033);
    chk(32'(mode_err), 0, "R3", "legal load");
    set_mode(10'h0A2);
    chk(32'(mode_err), 1, "R3", "reserved op mode flag");
    read_check(8, "R3", "R3");
    set_mode(10'h012);
    chk(32'(mode_err), 1, "R3", "reserved latency flag");
    set_mode(10'h03A);
    chk(32'(mode_err), 1, "R3", "reserved ordering flag");
    set_mode(10'h022);
    chk(32'(mode_err), 0, "R3", "flag cleared");

    // R9: read at edge n+2 cuts a 4-word read, stream stays unbroken
    @(negedge clk);
    cmd = 2'b01; addr = AW'(4);
    for (int j = 0; j <= cur_m + 6; j++) begin
      int idx;
      logic [DW-1:0] ed;
      @(negedge clk);
      if (j == 0) cmd = 2'b00;
      if (j == 1) begin cmd = 2'b01; addr = AW'(13); end
      if (j == 2) cmd = 2'b00;
      idx = j - cur_m;
      ed = (idx < 0 || idx >= 6) ? '0 :
           (idx < 2) ? em[wrap(4, idx, 4)] : em[wrap(13, idx - 2, 4)];
      chk(32'(dq_oe), 32'((j >= cur_m - 1) && (j <= cur_m + 5)), "R9", "oe back-to-back");
      chk(32'(dq_valid), 32'(idx >= 0 && idx < 6), "R9", "valid back-to-back");
      chk(32'(dq_out), 32'(ed), "R9", "word back-to-back");
    end

    // R9: write cut off after two words by a new write
    @(negedge clk);
    cmd = 2'b10; addr = AW'(16); dq_in = 16'hA0A0;
    @(negedge clk);
    cmd = 2'b00; dq_in = 16'hA0A1;
    @(negedge clk);
    cmd = 2'b10; addr = AW'(24); dq_in = 16'hB0B0;
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      cmd = 2'b00; dq_in = 16'hB0B0 + DW'(k);
    end
    @(negedge clk);
    cmd = 2'b00; dq_in = '0;
    em[16] = 16'hA0A0; em[17] = 16'hA0A1;
    for (int k = 0; k < 4; k++) em[24 + k] = 16'hB0B0 + DW'(k);
    read_check(16, "R9", "R4");
    read_check(24, "R7", "R4");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule